// File: doc/BRIEF.md
# Memory-Mapped Copy Engine

This block moves a run of data words from a source address space to a destination address space on its own. Software programs a source pointer, a destination pointer, a byte count and a control word through a small register port, then sets the start bit. From then on the engine issues reads on its read host port, parks the returned words in a shallow internal FIFO, and issues writes on its write host port until the transfer ends. The data is passed through bit for bit; the engine never looks at it or reorders bytes.

Each side can either walk upward through memory by one word per access or stay on one fixed address, which suits a peripheral data register. A transfer ends when the programmed byte count has been written, or early when the source marks a returned word as the end of a packet, or when the destination flags end of packet on an accepted write. The status word records which of these happened, and an interrupt line can be raised when the transfer finishes.

Top module: `dma_copy_engine`

## Requirements
- R1: After reset the status word (offset 0) reads 0x04 (only the length-zero bit), `irq` is low and neither host port requests.
- R2: Register word offsets are: 0 status, 1 source pointer, 2 destination pointer, 3 byte count, 6 control. Control bits: 0 start, 1 interrupt enable, 2 fixed source, 3 fixed destination, 4 stop on source end-of-packet, 5 stop on destination end-of-packet, 6 stop on count. Status bits: 0 done, 1 busy, 2 byte count is zero, 3 ended by source end-of-packet, 4 ended by destination end-of-packet. Pointers, count and control read back what was written; the two low bits of the count are stored as zero.
- R3: With both sides incrementing, the word read from source+4i is written unchanged to destination+4i, in order.
- R4: A side marked fixed uses the programmed pointer for every access of the transfer.
- R5: With stop-on-count set, exactly count/4 reads and count/4 writes take place, the count drops by 4 on each accepted write (never below zero), and the transfer finishes with status 0x05.
- R6: With stop-on-source-EOP set, the returned word carrying end-of-packet is the last one written and status bit 3 is set; with that control bit clear, source end-of-packet has no effect.
- R7: With stop-on-destination-EOP set, the write accepted with end-of-packet is the last write; words still queued or in flight are dropped and status bit 4 is set.
- R8: `irq` is high exactly while done is set and interrupt enable is set; writing any value to offset 0 clears done.
- R9: A request held against waitrequest keeps its address and data; at most 4 reads are in flight and the FIFO never overflows.
- R10: While busy, writes to offsets 1, 2, 3 and 6 are ignored; a start only takes effect from idle. When idle neither host port requests.
- R11: Starting with a byte count of zero and stop-on-count set finishes with status 0x05 and no bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register word offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears the next cycle |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| src_rd | output | 1 | Read request on the source port |
| src_addr | output | ADDR_W | Source byte address |
| src_wait | input | 1 | Source waitrequest |
| src_rdata | input | DATA_W | Returned read data |
| src_rvalid | input | 1 | Returned read data valid |
| src_eop | input | 1 | End of packet, qualified by `src_rvalid` |
| dst_wr | output | 1 | Write request on the destination port |
| dst_addr | output | ADDR_W | Destination byte address |
| dst_wdata | output | DATA_W | Write data |
| dst_wait | input | 1 | Destination waitrequest |
| dst_eop | input | 1 | End of packet, qualified by an accepted write |

## Verification
Fixed-count copies run with every mix of fixed and incrementing sides under random waitrequest rates and random read latency, which separates address stepping faults from data path and ordering faults. Source end-of-packet and destination end-of-packet are each injected partway through a long transfer, once with the matching stop bit set and once with it clear, which tells an early stop apart from an ignored flag and shows that dropped words never reach the destination. A zero byte count, register writes while busy and the interrupt enable both on and off cover the start and finish corners.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int REG_W = 32;

  localparam logic [2:0] OFS_STATUS = 3'd0;
  localparam logic [2:0] OFS_SRC    = 3'd1;
  localparam logic [2:0] OFS_DST    = 3'd2;
  localparam logic [2:0] OFS_COUNT  = 3'd3;
  localparam logic [2:0] OFS_CTRL   = 3'd6;

  localparam int CTRL_W = 7;

  typedef struct packed {
    logic stop_cnt;
    logic stop_deop;
    logic stop_seop;
    logic dst_fixed;
    logic src_fixed;
    logic int_en;
    logic start;
  } ctrl_t;
endpackage

// File: rtl/dma_fifo.sv
module dma_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign dout  = mem[rp];
  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              finish,
  input  logic              len_step,
  input  logic              seop_hit,
  input  logic              deop_hit,
  output logic              start,
  output logic              busy,
  output logic              done,
  output ctrl_t             ctrl,
  output logic [ADDR_W-1:0] src_ptr,
  output logic [ADDR_W-1:0] dst_ptr,
  output logic [LEN_W-1:0]  count,
  output logic              irq
);
  localparam int BSH = $clog2(BYTES);

  logic cfg_wr, done_d, seop_flag, deop_flag;
  ctrl_t ctrl_d;

  assign cfg_wr = reg_wr && !busy;
  assign start  = cfg_wr && (reg_addr == OFS_CTRL) && reg_wdata[0];

  always_comb begin
    ctrl_d = ctrl;
    if (cfg_wr && reg_addr == OFS_CTRL) ctrl_d = ctrl_t'(reg_wdata[CTRL_W-1:0]);
    done_d = done;
    if (reg_wr && reg_addr == OFS_STATUS) done_d = 1'b0;
    if (start)  done_d = 1'b0;
    if (finish) done_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      ctrl      <= '0;
      src_ptr   <= '0;
      dst_ptr   <= '0;
      count     <= '0;
      seop_flag <= 1'b0;
      deop_flag <= 1'b0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      done <= done_d;
      ctrl <= ctrl_d;
      irq  <= done_d && ctrl_d.int_en;
      if (start)       busy <= 1'b1;
      else if (finish) busy <= 1'b0;
      if (cfg_wr && reg_addr == OFS_SRC) src_ptr <= reg_wdata[ADDR_W-1:0];
      if (cfg_wr && reg_addr == OFS_DST) dst_ptr <= reg_wdata[ADDR_W-1:0];
      if (cfg_wr && reg_addr == OFS_COUNT)
        count <= {reg_wdata[LEN_W-1:BSH], {BSH{1'b0}}};
      else if (len_step)
        count <= (count >= LEN_W'(BYTES)) ? count - LEN_W'(BYTES) : '0;
      if (start) begin
        seop_flag <= 1'b0;
        deop_flag <= 1'b0;
      end else begin
        if (seop_hit) seop_flag <= 1'b1;
        if (deop_hit) deop_flag <= 1'b1;
      end
      if (reg_rd) begin
        case (reg_addr)
          OFS_STATUS: reg_rdata <= REG_W'({deop_flag, seop_flag, count == '0, busy, done});
          OFS_SRC:    reg_rdata <= REG_W'(src_ptr);
          OFS_DST:    reg_rdata <= REG_W'(dst_ptr);
          OFS_COUNT:  reg_rdata <= REG_W'(count);
          OFS_CTRL:   reg_rdata <= REG_W'(ctrl);
          default:    reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_rd_side.sv
module dma_rd_side #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int BYTES   = 4,
  parameter int DEPTH   = 8,
  parameter int MAX_OUT = 4,
  parameter int CNT_W   = $clog2(DEPTH + 1),
  parameter int OUT_W   = $clog2(MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  words,
  input  logic              fixed,
  input  logic              limit,
  input  logic              run,
  input  logic              push,
  input  logic              pop,
  input  logic [CNT_W-1:0]  fifo_count,
  input  logic              rvalid,
  input  logic              wait_in,
  output logic              req,
  output logic [ADDR_W-1:0] addr,
  output logic [OUT_W-1:0]  outstanding
);
  logic             acc, may;
  logic [15:0]      out_n, fill_n, resv_n;
  logic [LEN_W-1:0] left, left_n;

  assign acc = req && !wait_in;

  always_comb begin
    out_n  = 16'(outstanding) + 16'(acc) - 16'(rvalid);
    fill_n = 16'(fifo_count) + 16'(push) - 16'(pop);
    resv_n = out_n + fill_n;
    left_n = left - LEN_W'(acc);
    may    = run && (out_n < 16'(MAX_OUT)) && (resv_n < 16'(DEPTH)) &&
             (!limit || left_n != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req         <= 1'b0;
      addr        <= '0;
      left        <= '0;
      outstanding <= '0;
    end else begin
      outstanding <= OUT_W'(out_n);
      if (start) begin
        req  <= 1'b0;
        addr <= base;
        left <= words;
      end else begin
        left <= left_n;
        req  <= (req && wait_in) || may;
        if (acc && !fixed) addr <= addr + ADDR_W'(BYTES);
      end
    end
  end
endmodule

// File: rtl/dma_wr_side.sv
module dma_wr_side #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic              fixed,
  input  logic              go,
  input  logic              empty,
  input  logic [DATA_W-1:0] head,
  input  logic              wait_in,
  output logic              req,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic              pop,
  output logic              acc
);
  logic free;

  assign acc  = req && !wait_in;
  assign free = !req || acc;
  assign pop  = free && go && !empty;

  always_ff @(posedge clk) begin
    if (pop) data <= head;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req  <= 1'b0;
      addr <= '0;
    end else if (start) begin
      req  <= 1'b0;
      addr <= base;
    end else begin
      if (free) req <= pop;
      if (acc && !fixed) addr <= addr + ADDR_W'(BYTES);
    end
  end
endmodule

// File: rtl/dma_copy_engine.sv
module dma_copy_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 16,
  parameter int DEPTH   = 8,
  parameter int MAX_OUT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              src_rd,
  output logic [ADDR_W-1:0] src_addr,
  input  logic              src_wait,
  input  logic [DATA_W-1:0] src_rdata,
  input  logic              src_rvalid,
  input  logic              src_eop,
  output logic              dst_wr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [DATA_W-1:0] dst_wdata,
  input  logic              dst_wait,
  input  logic              dst_eop
);
  localparam int BYTES = DATA_W / 8;
  localparam int BSH   = $clog2(BYTES);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int OUT_W = $clog2(MAX_OUT + 1);

  logic              start, busy, done, finish;
  ctrl_t             ctrl;
  logic [ADDR_W-1:0] src_ptr, dst_ptr;
  logic [LEN_W-1:0]  count;
  logic              halt_rd, halt_wr, seop_hit, deop_hit;
  logic              push, fifo_pop, wr_pop, wr_acc, wr_go, rd_run;
  logic [DATA_W-1:0] head;
  logic [CNT_W-1:0]  fill;
  logic              empty, full;
  logic [OUT_W-1:0]  outstanding;
  logic              pipe_empty;

  assign seop_hit = src_rvalid && src_eop && ctrl.stop_seop && busy && !halt_rd;
  assign deop_hit = wr_acc && dst_eop && ctrl.stop_deop && busy && !halt_wr;
  assign push     = src_rvalid && busy && !halt_rd;
  assign wr_go    = busy && !halt_wr && !deop_hit;
  assign rd_run   = busy && !halt_rd && !seop_hit && !deop_hit;
  assign fifo_pop = wr_pop || (halt_wr && !empty);

  assign pipe_empty = (outstanding == '0) && !src_rd && empty && !dst_wr;
  assign finish     = busy && pipe_empty && ((ctrl.stop_cnt && count == '0) || halt_rd);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      halt_rd <= 1'b0;
      halt_wr <= 1'b0;
    end else begin
      if (seop_hit || deop_hit) halt_rd <= 1'b1;
      if (deop_hit)             halt_wr <= 1'b1;
    end
  end

  dma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BYTES(BYTES)) u_regs (
    .clk(clk), .rst(rst),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .finish(finish), .len_step(wr_acc && busy),
    .seop_hit(seop_hit), .deop_hit(deop_hit),
    .start(start), .busy(busy), .done(done), .ctrl(ctrl),
    .src_ptr(src_ptr), .dst_ptr(dst_ptr), .count(count), .irq(irq)
  );

  dma_rd_side #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BYTES(BYTES),
                .DEPTH(DEPTH), .MAX_OUT(MAX_OUT)) u_rd (
    .clk(clk), .rst(rst), .start(start),
    .base(src_ptr), .words(count >> BSH),
    .fixed(ctrl.src_fixed), .limit(ctrl.stop_cnt), .run(rd_run),
    .push(push), .pop(fifo_pop), .fifo_count(fill),
    .rvalid(src_rvalid), .wait_in(src_wait),
    .req(src_rd), .addr(src_addr), .outstanding(outstanding)
  );

  dma_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(push), .din(src_rdata), .pop(fifo_pop), .dout(head),
    .count(fill), .empty(empty), .full(full)
  );

  dma_wr_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTES(BYTES)) u_wr (
    .clk(clk), .rst(rst), .start(start),
    .base(dst_ptr), .fixed(ctrl.dst_fixed), .go(wr_go),
    .empty(empty), .head(head), .wait_in(dst_wait),
    .req(dst_wr), .addr(dst_addr), .data(dst_wdata),
    .pop(wr_pop), .acc(wr_acc)
  );
endmodule

// File: rtl/dma_copy_chk.sv
module dma_copy_chk #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 16,
  parameter int MAX_OUT = 4,
  parameter int OUT_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              src_rd,
  input logic              src_wait,
  input logic [ADDR_W-1:0] src_addr,
  input logic              dst_wr,
  input logic              dst_wait,
  input logic [ADDR_W-1:0] dst_addr,
  input logic [DATA_W-1:0] dst_wdata,
  input logic              src_fixed,
  input logic              dst_fixed,
  input logic [LEN_W-1:0]  count,
  input logic [OUT_W-1:0]  outstanding,
  input logic              push,
  input logic              full
);
  localparam int BYTES = DATA_W / 8;

  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (rst)
    src_rd && src_wait |=> src_rd && $stable(src_addr)); // R9
  AST_DST_HOLD: assert property (@(posedge clk) disable iff (rst)
    dst_wr && dst_wait |=> dst_wr && $stable(dst_addr) && $stable(dst_wdata)); // R9
  AST_INFLIGHT_CAP: assert property (@(posedge clk) disable iff (rst)
    32'(outstanding) <= MAX_OUT); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> !full); // R9
  AST_SRC_FIXED: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) && src_fixed |-> $stable(src_addr)); // R4
  AST_DST_FIXED: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) && dst_fixed |-> $stable(dst_addr)); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    busy && dst_wr && !dst_wait |=>
      count == (($past(count) >= LEN_W'(BYTES)) ? $past(count) - LEN_W'(BYTES) : '0)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !src_rd && !dst_wr); // R10
endmodule

bind dma_copy_engine dma_copy_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
  .MAX_OUT(MAX_OUT), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy),
  .src_rd(src_rd), .src_wait(src_wait), .src_addr(src_addr),
  .dst_wr(dst_wr), .dst_wait(dst_wait), .dst_addr(dst_addr), .dst_wdata(dst_wdata),
  .src_fixed(ctrl.src_fixed), .dst_fixed(ctrl.dst_fixed),
  .count(count), .outstanding(outstanding), .push(push), .full(full)
);

// File: tb/sim_dma_copy_engine.sv
module sim_dma_copy_engine;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    reg_addr = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq;
  logic          src_rd, dst_wr;
  logic [AW-1:0] src_addr, dst_addr;
  logic [DW-1:0] dst_wdata;
  logic          src_wait = 1'b0, src_rvalid = 1'b0, src_eop = 1'b0;
  logic [DW-1:0] src_rdata = '0;
  logic          dst_wait = 1'b0, dst_eop = 1'b0;

  always #5 clk = ~clk;

  dma_copy_engine u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .src_rd(src_rd), .src_addr(src_addr), .src_wait(src_wait),
    .src_rdata(src_rdata), .src_rvalid(src_rvalid), .src_eop(src_eop),
    .dst_wr(dst_wr), .dst_addr(dst_addr), .dst_wdata(dst_wdata),
    .dst_wait(dst_wait), .dst_eop(dst_eop)
  );

  int checks = 0, fails = 0, cyc = 0;
  int rwait_pct = 0, wwait_pct = 0, seop_at = -1, deop_at = -1;
  int rcnt = 0, rdel = 0, wcnt = 0, max_out = 0;
  logic [31:0] pend_a[$];
  int          pend_t[$];
  logic [31:0] wlog_a [256];
  logic [31:0] wlog_d [256];
  logic        s_rreq = 0, s_rwait = 0, s_wreq = 0, s_wwait = 0;
  logic [31:0] s_raddr = 0, s_waddr = 0, s_wdata = 0;

  function automatic logic [31:0] srcf(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Bus models: act on what the last rising edge accepted, then drive anew.
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (s_rreq && !s_rwait) begin
        pend_a.push_back(s_raddr);
        pend_t.push_back(cyc + 1 + int'($urandom % 4));
        rcnt++;
      end
      if (s_wreq && !s_wwait) begin
        if (wcnt < 256) begin
          wlog_a[wcnt] = s_waddr;
          wlog_d[wcnt] = s_wdata;
        end
        wcnt++;
      end
      if (rcnt - rdel > max_out) max_out = rcnt - rdel;
    end
    src_rvalid = 1'b0;
    src_eop    = 1'b0;
    if (pend_a.size() > 0 && pend_t[0] <= cyc && ($urandom % 4) != 0) begin
      src_rvalid = 1'b1;
      src_rdata  = srcf(pend_a[0]);
      src_eop    = (rdel == seop_at);
      void'(pend_a.pop_front());
      void'(pend_t.pop_front());
      rdel++;
    end
    src_wait = (int'($urandom % 100) < rwait_pct);
    dst_wait = (int'($urandom % 100) < wwait_pct);
    dst_eop  = dst_wr && !dst_wait && (wcnt == deop_at);
    s_rreq = src_rd; s_raddr = src_addr; s_rwait = src_wait;
    s_wreq = dst_wr; s_waddr = dst_addr; s_wdata = dst_wdata; s_wwait = dst_wait;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  task automatic csr_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic csr_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_done(output logic [31:0] st);
    st = '0;
    for (int i = 0; i < 20000; i++) begin
      csr_read(3'd0, st);
      if (st[0]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic launch(input logic [31:0] src, input logic [31:0] dst,
                        input logic [31:0] len, input logic [6:0] ctl);
    rcnt = 0; rdel = 0; wcnt = 0;
    csr_write(3'd1, src);
    csr_write(3'd2, dst);
    csr_write(3'd3, len);
    csr_write(3'd6, {25'd0, ctl} | 32'd1);
  endtask

  function automatic int bad_writes(input logic [31:0] src, input logic [31:0] dst,
                                    input int n, input bit sfix, input bit dfix);
    int bad = 0;
    for (int i = 0; i < n && i < 256; i++) begin
      logic [31:0] ea = dfix ? dst : dst + 32'(4 * i);
      logic [31:0] ed = srcf(sfix ? src : src + 32'(4 * i));
      if (wlog_a[i] !== ea || wlog_d[i] !== ed) bad++;
    end
    return bad;
  endfunction

  initial begin
    logic [31:0] st, v;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    csr_read(3'd0, st);
    chk(st == 32'h4, "R1 status after reset", st, 32'h4);
    chk(!irq && !src_rd && !dst_wr, "R1 idle outputs", {irq, src_rd, dst_wr}, 0);

    // R2 readback, low count bits dropped, no start
    csr_write(3'd1, 32'h0000_1230);
    csr_write(3'd2, 32'h0000_8800);
    csr_write(3'd3, 32'h0000_0027);
    csr_write(3'd6, 32'h0000_0076);
    csr_read(3'd1, v); chk(v == 32'h1230, "R2 source pointer", v, 32'h1230);
    csr_read(3'd2, v); chk(v == 32'h8800, "R2 destination pointer", v, 32'h8800);
    csr_read(3'd3, v); chk(v == 32'h24, "R2 count low bits", v, 32'h24);
    csr_read(3'd6, v); chk(v == 32'h76, "R2 control", v, 32'h76);
    csr_read(3'd0, v); chk(v == 32'h0, "R2 no start without bit0", v, 32'h0);

    // R3 R5 R8 plain incrementing copy
    rwait_pct = 20; wwait_pct = 20;
    launch(32'h1000, 32'h4000, 32'd32, 7'h42);
    wait_done(st);
    chk(st == 32'h5, "R5 status on count end", st, 32'h5);
    chk(wcnt == 8 && rcnt == 8, "R5 access counts", {wcnt[15:0], rcnt[15:0]}, 32'h0008_0008);
    v = 32'(bad_writes(32'h1000, 32'h4000, 8, 0, 0));
    chk(v == 0, "R3 copied words", v, 0);
    chk(irq, "R8 irq raised", irq, 1);
    csr_write(3'd0, 32'h0);
    @(negedge clk);
    csr_read(3'd0, st);
    chk(st == 32'h4 && !irq, "R8 status write clears done", {irq, st[30:0]}, 32'h4);

    // R4 fixed sides
    launch(32'h2000, 32'h6000, 32'd24, 7'h44);
    wait_done(st);
    v = 32'(bad_writes(32'h2000, 32'h6000, 6, 1, 0));
    chk(wcnt == 6 && v == 0, "R4 fixed source", v, 0);
    launch(32'h2100, 32'h6100, 32'd24, 7'h48);
    wait_done(st);
    v = 32'(bad_writes(32'h2100, 32'h6100, 6, 0, 1));
    chk(wcnt == 6 && v == 0, "R4 fixed destination", v, 0);
    chk(!irq, "R8 irq stays low when disabled", irq, 0);

    // random trials
    for (int t = 0; t < 8; t++) begin
      int n = 1 + int'($urandom % 24);
      bit sf = $urandom % 2, df = $urandom % 2, ie = $urandom % 2;
      logic [31:0] sa = 32'h10000 + 32'($urandom % 256) * 4;
      logic [31:0] da = 32'h20000 + 32'($urandom % 256) * 4;
      rwait_pct = int'($urandom % 60); wwait_pct = int'($urandom % 60);
      launch(sa, da, 32'(4 * n), {1'b1, 3'b000, 1'b0, 2'b00} | {3'b000, df, sf, ie, 1'b0});
      wait_done(st);
      v = 32'(bad_writes(sa, da, n, sf, df));
      chk(wcnt == n && rcnt == n && v == 0, "R3 R4 R5 random copy", v, 0);
      chk(st == 32'h5 && irq == ie, "R8 random status and irq", {irq, st[30:0]}, {ie, 31'h5});
      csr_write(3'd0, 32'h0);
    end

    // R6 source end-of-packet stops the copy
    rwait_pct = 10; wwait_pct = 30; seop_at = 5;
    launch(32'h3000, 32'h7000, 32'd400, 7'h52);
    wait_done(st);
    v = 32'(bad_writes(32'h3000, 32'h7000, 6, 0, 0));
    chk(wcnt == 6 && v == 0, "R6 last write is eop word", wcnt, 6);
    chk(st == 32'h9, "R6 status source eop", st, 32'h9);
    // R6 ignored when stop bit clear
    seop_at = 2;
    launch(32'h3000, 32'h7000, 32'd32, 7'h40);
    wait_done(st);
    chk(wcnt == 8 && st == 32'h5, "R6 eop ignored", wcnt, 8);
    seop_at = -1;

    // R7 destination end-of-packet
    rwait_pct = 5; wwait_pct = 40; deop_at = 3;
    launch(32'h5000, 32'h9000, 32'd400, 7'h60);
    wait_done(st);
    v = 32'(bad_writes(32'h5000, 32'h9000, 4, 0, 0));
    chk(wcnt == 4 && v == 0, "R7 writes stop at eop", wcnt, 4);
    chk(st == 32'h11, "R7 status destination eop", st, 32'h11);
    deop_at = -1;

    // R10 writes while busy ignored
    rwait_pct = 70; wwait_pct = 70;
    launch(32'hA000, 32'hB000, 32'd64, 7'h40);
    csr_write(3'd3, 32'd8);
    csr_write(3'd2, 32'hC000);
    csr_write(3'd6, 32'h4D);
    wait_done(st);
    v = 32'(bad_writes(32'hA000, 32'hB000, 16, 0, 0));
    chk(wcnt == 16 && v == 0, "R10 busy writes ignored", wcnt, 16);
    csr_read(3'd6, v);
    chk(v == 32'h41, "R10 control unchanged", v, 32'h41);

    // R11 zero count
    rwait_pct = 0; wwait_pct = 0;
    launch(32'hD000, 32'hE000, 32'd0, 7'h40);
    wait_done(st);
    chk(st == 32'h5 && wcnt == 0 && rcnt == 0, "R11 zero count", {wcnt[15:0], st[15:0]}, 32'h5);

    chk(max_out <= 4, "R9 reads in flight", max_out, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule